// File: doc/BRIEF.md
# Synthesiser Tuning Register Slave (I2C)

This block is the serial control front end of a frequency synthesiser. It listens on a two-wire I2C bus, oversampled by the system clock. It answers to one of four selectable slave addresses and turns the received bytes into the synthesiser's settings: a 17-bit loop division ratio, a prescaler enable, a 4-bit reference-divider code, four port bits and four test bits. In read mode it returns a status byte whose top bit reports that a power-on reset has taken place.

Write data needs no register pointer. The leading bit of each unpaired byte says whether it opens a frequency pair or a control pair, and the byte after it is that byte's partner. Control fields take effect as soon as their byte arrives. The division ratio is different: it is collected in staging registers and moves to the output in one step. That step happens only when all 17 bits have arrived, or when a STOP closes a transfer that delivered ratio bytes. A fine tune therefore never shows a half-updated ratio.

Top module: `synth_i2c_ctrl`

## Requirements
- R1: The 7-bit slave address is `{ADDR_BASE[6:2], addrSel}`, with a default base of 7'h60. Address bit 0 (the last bit sent) selects write (0) or read (1). A non-matching address gets no acknowledge, and the data bytes that follow it change no output until the next START.
- R2: After a matching address and after every write data byte, the slave asserts `sdaOe` (pulls SDA low) through the ninth clock.
- R3: In read mode the slave sends the status byte MSB first. Bit 7 holds the power-on flag and bits 6:0 read 0. A master acknowledge (SDA low) requests another status byte. A master non-acknowledge ends the transfer, and the slave drives nothing until the next START.
- R4: An unpaired byte with bit 7 = 0 is a frequency-high byte whose bits 6:0 are ratio[14:8]. Its partner byte is ratio[7:0]. An unpaired byte with bit 7 = 1 is a control-A byte: bits 6:5 are ratio[16:15], bit 4 is the prescaler enable and bits 3:0 are the reference code. Its partner is a control-B byte with test bits in 7:4 and port bits in 3:0. Pairs repeat without readdressing, and a START begins a new pairing.
- R5: `prescEn` and `refCode` update at the end of a control-A byte. `testBits` and `portBits` update at the end of a control-B byte.
- R6: `ratioOut` takes the staged value once frequency-high, frequency-low and control-A bytes have all been received since the last commit. Sending only frequency pairs, with no STOP, leaves `ratioOut` unchanged.
- R7: A STOP that follows at least one ratio byte since the last commit commits the staged ratio, and the parts not resent keep their last staged values. A byte cut short by a STOP is discarded.
- R8: The power-on flag is 1 after reset and clears once a status byte has been fully sent.
- R9: After reset, every configuration output is 0 and `sdaOe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset (power-on) |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| addrSel | input | 2 | Strap selecting the low address bits |
| sdaOe | output | 1 | 1 pulls the data line low |
| ratioOut | output | 17 | Committed loop division ratio |
| prescEn | output | 1 | Prescaler enable |
| refCode | output | 4 | Reference divider ratio code |
| portBits | output | 4 | Output port bits |
| testBits | output | 4 | Test mode bits |

## Verification
The assertions check four things on every cycle. The slave only starts pulling SDA low right after a detected SCL fall. The committed ratio moves only after a completed byte or a STOP. The prescaler and reference fields move only after a completed byte. The power-on flag drops only when a status byte has finished. The bench scenarios cover what no single-cycle property can show: the values that end up committed, which byte orders commit, the address match across all strap and address combinations, discarding of a cut-off byte, and the read sequence, which ends after a non-acknowledge.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int RATIO_W = 17;
  localparam int HI_W    = 7;
  localparam int AUX_W   = RATIO_W - HI_W - BYTE_W;
  localparam int NIB_W   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_HOLD, ST_ACK, ST_TX, ST_MACK
  } busState_e;

  typedef struct packed {
    logic              byteValid;
    logic [BYTE_W-1:0] byteData;
    logic              startSeen;
    logic              stopSeen;
    logic              porClear;
  } strobe_t;
endpackage

// File: rtl/synth_i2c_sync.sv
module synth_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prevLevel;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[gi] <= 1'b1;
        else if (gi == 0) chain[gi] <= din;
        else chain[gi] <= chain[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prevLevel <= 1'b1;
    else prevLevel <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prevLevel;
  assign fall  = ~level & prevLevel;
endmodule

// File: rtl/synth_i2c_control.sv
module synth_i2c_control
  import synth_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE  = 7'h60,
  parameter int         ADDR_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclLvl,
  input  logic                  sclRise,
  input  logic                  sclFall,
  input  logic                  sdaLvl,
  input  logic                  sdaRise,
  input  logic                  sdaFall,
  input  logic [ADDR_SEL_W-1:0] addrSel,
  input  logic [BYTE_W-1:0]     statusByte,
  output strobe_t               stb,
  output logic                  sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  busState_e         state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] txShift;
  logic              isAddr, isRead, masterAck;
  logic              startCond, stopCond, addrMatch;

  assign startCond = sdaFall & sclLvl;
  assign stopCond  = sdaRise & sclLvl;
  assign addrMatch = (shiftReg == {ADDR_BASE[6:ADDR_SEL_W], addrSel});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      txShift   <= '0;
      isAddr    <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      stb       <= '0;
    end else begin
      stb.byteValid <= 1'b0;
      stb.startSeen <= 1'b0;
      stb.stopSeen  <= 1'b0;
      stb.porClear  <= 1'b0;
      if (startCond) begin
        state         <= ST_RX;
        isAddr        <= 1'b1;
        bitCnt        <= '0;
        stb.startSeen <= 1'b1;
      end else if (stopCond) begin
        state        <= ST_IDLE;
        stb.stopSeen <= 1'b1;
      end else begin
        case (state)
          ST_RX: if (sclRise) begin
            shiftReg <= {shiftReg[BYTE_W-3:0], sdaLvl};
            bitCnt   <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) begin
              if (isAddr) begin
                isRead <= sdaLvl;
                state  <= addrMatch ? ST_HOLD : ST_IDLE;
              end else begin
                stb.byteValid <= 1'b1;
                stb.byteData  <= {shiftReg, sdaLvl};
                state         <= ST_HOLD;
              end
            end
          end
          ST_HOLD: if (sclFall) state <= ST_ACK;
          ST_ACK: if (sclFall) begin
            bitCnt <= '0;
            isAddr <= 1'b0;
            if (isAddr && isRead) begin
              state   <= ST_TX;
              txShift <= statusByte;
            end else begin
              state <= ST_RX;
            end
          end
          ST_TX: if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              state        <= ST_MACK;
              stb.porClear <= 1'b1;
            end else begin
              txShift <= {txShift[BYTE_W-2:0], 1'b0};
              bitCnt  <= bitCnt + 1'b1;
            end
          end
          ST_MACK: begin
            if (sclRise) masterAck <= ~sdaLvl;
            if (sclFall) begin
              if (masterAck) begin
                state   <= ST_TX;
                txShift <= statusByte;
                bitCnt  <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe = (state == ST_ACK) | ((state == ST_TX) & ~txShift[BYTE_W-1]);
endmodule

// File: rtl/synth_i2c_datapath.sv
module synth_i2c_datapath
  import synth_i2c_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            stb,
  output logic [RATIO_W-1:0] ratioOut,
  output logic               prescEn,
  output logic [NIB_W-1:0]   refCode,
  output logic [NIB_W-1:0]   portBits,
  output logic [NIB_W-1:0]   testBits,
  output logic [BYTE_W-1:0]  statusByte
);
  logic [HI_W-1:0]   stageHi, nHi;
  logic [BYTE_W-1:0] stageLo, nLo;
  logic [AUX_W-1:0]  stageAux, nAux;
  logic gotHi, gotLo, gotAux, ngHi, ngLo, ngAux;
  logic secondByte, kindFreq, commit, porFlag;
  logic [BYTE_W-1:0] b;

  assign b = stb.byteData;

  always_comb begin
    nHi = stageHi; nLo = stageLo; nAux = stageAux;
    ngHi = gotHi;  ngLo = gotLo;  ngAux = gotAux;
    if (stb.byteValid) begin
      if (!secondByte) begin
        if (!b[BYTE_W-1]) begin
          nHi  = b[HI_W-1:0];
          ngHi = 1'b1;
        end else begin
          nAux  = b[6:5];
          ngAux = 1'b1;
        end
      end else if (kindFreq) begin
        nLo  = b;
        ngLo = 1'b1;
      end
    end
    commit = (stb.byteValid & ngHi & ngLo & ngAux) |
             (stb.stopSeen & (gotHi | gotLo | gotAux));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageHi <= '0; stageLo <= '0; stageAux <= '0;
      gotHi <= 1'b0; gotLo <= 1'b0; gotAux <= 1'b0;
      secondByte <= 1'b0; kindFreq <= 1'b0;
      ratioOut <= '0; prescEn <= 1'b0; refCode <= '0;
      portBits <= '0; testBits <= '0;
      porFlag <= 1'b1;
    end else begin
      stageHi  <= nHi;
      stageLo  <= nLo;
      stageAux <= nAux;
      gotHi    <= ngHi & ~commit;
      gotLo    <= ngLo & ~commit;
      gotAux   <= ngAux & ~commit;
      if (commit) ratioOut <= {nAux, nHi, nLo};
      if (stb.porClear) porFlag <= 1'b0;
      if (stb.startSeen) begin
        secondByte <= 1'b0;
      end else if (stb.byteValid) begin
        if (!secondByte) begin
          secondByte <= 1'b1;
          kindFreq   <= ~b[BYTE_W-1];
          if (b[BYTE_W-1]) begin
            prescEn <= b[4];
            refCode <= b[NIB_W-1:0];
          end
        end else begin
          secondByte <= 1'b0;
          if (!kindFreq) begin
            testBits <= b[BYTE_W-1:NIB_W];
            portBits <= b[NIB_W-1:0];
          end
        end
      end
    end
  end

  assign statusByte = {porFlag, {(BYTE_W-1){1'b0}}};
endmodule

// File: rtl/synth_i2c_ctrl.sv
module synth_i2c_ctrl
  import synth_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE  = 7'h60,
  parameter int         ADDR_SEL_W = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [ADDR_SEL_W-1:0] addrSel,
  output logic                  sdaOe,
  output logic [RATIO_W-1:0]    ratioOut,
  output logic                  prescEn,
  output logic [NIB_W-1:0]      refCode,
  output logic [NIB_W-1:0]      portBits,
  output logic [NIB_W-1:0]      testBits
);
  logic sclLvl, sclRise, sclFall, sdaLvl, sdaRise, sdaFall;
  logic [BYTE_W-1:0] statusByte;
  strobe_t stb;

  synth_i2c_sync #(.STAGES(SYNC_STAGES)) sclSync_i (
    .clk(clk), .rst_n(rst_n), .din(sclIn),
    .level(sclLvl), .rise(sclRise), .fall(sclFall));

  synth_i2c_sync #(.STAGES(SYNC_STAGES)) sdaSync_i (
    .clk(clk), .rst_n(rst_n), .din(sdaIn),
    .level(sdaLvl), .rise(sdaRise), .fall(sdaFall));

  synth_i2c_control #(.ADDR_BASE(ADDR_BASE), .ADDR_SEL_W(ADDR_SEL_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .sclLvl(sclLvl), .sclRise(sclRise), .sclFall(sclFall),
    .sdaLvl(sdaLvl), .sdaRise(sdaRise), .sdaFall(sdaFall),
    .addrSel(addrSel), .statusByte(statusByte),
    .stb(stb), .sdaOe(sdaOe));

  synth_i2c_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .ratioOut(ratioOut), .prescEn(prescEn), .refCode(refCode),
    .portBits(portBits), .testBits(testBits), .statusByte(statusByte));
endmodule

// File: rtl/synth_i2c_ctrl_checker.sv
module synth_i2c_ctrl_checker
  import synth_i2c_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sdaOe,
  input logic               sclFall,
  input strobe_t            stb,
  input logic [RATIO_W-1:0] ratioOut,
  input logic               prescEn,
  input logic [NIB_W-1:0]   refCode,
  input logic               porFlag
);
  // R2: the slave only begins to pull SDA low just after SCL has fallen
  assert_oe_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaOe) |-> $past(sclFall));

  // R5: control-A fields move only after a completed byte
  assert_ctrl_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({prescEn, refCode}) |-> $past(stb.byteValid));

  // R6 and R7: the ratio moves only after a completed byte or a STOP
  assert_ratio_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratioOut) |-> $past(stb.byteValid || stb.stopSeen));

  // R8: the power-on flag drops only when a status byte has finished
  assert_por_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(porFlag) |-> $past(stb.porClear));
endmodule

bind synth_i2c_ctrl synth_i2c_ctrl_checker chk_i (
  .clk(clk), .rst_n(rst_n), .sdaOe(sdaOe), .sclFall(sclFall), .stb(stb),
  .ratioOut(ratioOut), .prescEn(prescEn), .refCode(refCode),
  .porFlag(dp_i.porFlag));

// File: tb/synth_i2c_ctrl_tb_top.sv
module synth_i2c_ctrl_tb_top;
  localparam int Q = 6;
  localparam logic [6:0] BASE = 7'h60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] addrSel = 2'd0;
  logic sdaOe, prescEn;
  logic [16:0] ratioOut;
  logic [3:0] refCode, portBits, testBits;
  logic sdaLine;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [16:0] eRatio = '0;
  logic [6:0]  stHi = '0;
  logic [7:0]  stLo = '0;
  logic [1:0]  stAux = '0;
  bit gH = 0, gL = 0, gA = 0, mSecond = 0, mKindF = 0;
  logic ePresc = 1'b0;
  logic [3:0] eRef = '0, ePort = '0, eTest = '0;

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  synth_i2c_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaOe(sdaOe), .ratioOut(ratioOut), .prescEn(prescEn), .refCode(refCode),
    .portBits(portBits), .testBits(testBits));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitq(); sclM = 1'b1; waitq();
    sdaM = 1'b0; waitq(); sclM = 1'b0; waitq();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitq(); sclM = 1'b1; waitq(); sdaM = 1'b1; waitq(); waitq();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitq(); sclM = 1'b1; waitq(); waitq(); sclM = 1'b0; waitq();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitq(); sclM = 1'b1; waitq();
    ack = ~sdaLine;
    waitq(); sclM = 1'b0; waitq();
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] d);
    sdaM = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      waitq(); sclM = 1'b1; waitq();
      d = {d[6:0], sdaLine};
      waitq(); sclM = 1'b0;
    end
    sdaM = ~mAck; waitq(); sclM = 1'b1; waitq(); waitq(); sclM = 1'b0; waitq();
    sdaM = 1'b1;
  endtask

  // Reference model of the requirements (R4..R7)
  task automatic mStart(); mSecond = 0; endtask

  task automatic mCommitIfFull();
    if (gH && gL && gA) begin eRatio = {stAux, stHi, stLo}; gH = 0; gL = 0; gA = 0; end
  endtask

  task automatic mByte(input logic [7:0] b);
    if (!mSecond) begin
      if (!b[7]) begin stHi = b[6:0]; gH = 1; mKindF = 1; end
      else begin stAux = b[6:5]; gA = 1; ePresc = b[4]; eRef = b[3:0]; mKindF = 0; end
      mSecond = 1;
    end else begin
      if (mKindF) begin stLo = b; gL = 1; end
      else begin eTest = b[7:4]; ePort = b[3:0]; end
      mSecond = 0;
    end
    mCommitIfFull();
  endtask

  task automatic mStop();
    if (gH || gL || gA) begin eRatio = {stAux, stHi, stLo}; gH = 0; gL = 0; gA = 0; end
  endtask

  task automatic addrWrite();
    logic ack;
    busStart(); mStart();
    sendByte({BASE[6:2], addrSel, 1'b0}, ack);
    check("R1 write address ack", 32'(ack), 32'd1);
  endtask

  task automatic writeData(input logic [7:0] b);
    logic ack;
    sendByte(b, ack);
    check("R2 data byte ack", 32'(ack), 32'd1);
    mByte(b);
  endtask

  task automatic checkOuts(input string tag);
    check({tag, " ratio"}, 32'(ratioOut), 32'(eRatio));
    check({tag, " presc"}, 32'(prescEn), 32'(ePresc));
    check({tag, " ref"},   32'(refCode), 32'(eRef));
    check({tag, " port"},  32'(portBits), 32'(ePort));
    check({tag, " test"},  32'(testBits), 32'(eTest));
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: reset state
    checkOuts("R9 reset");
    check("R9 reset sdaOe", 32'(sdaOe), 32'd0);

    // R3, R8: status reads
    busStart();
    sendByte({BASE[6:2], addrSel, 1'b1}, ack);
    check("R1 read address ack", 32'(ack), 32'd1);
    readByte(1'b1, d);
    check("R8 first status has flag", 32'(d), 32'h80);
    readByte(1'b0, d);
    check("R8 flag cleared after read", 32'(d), 32'h00);
    readByte(1'b0, d);
    check("R3 no drive after nack", 32'(d), 32'hFF);
    busStop();

    // R1: address sweep with a control byte after a mismatch
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 4; a++) begin
        addrSel = 2'(s);
        busStart(); mStart();
        sendByte({BASE[6:2], 2'(a), 1'b0}, ack);
        check("R1 address match", 32'(ack), 32'(s == a));
        if (s != a) begin
          sendByte(8'hFF, ack);
          check("R1 ignored byte not acked", 32'(ack), 32'd0);
        end
        busStop();
        checkOuts("R1 after sweep");
      end
    end

    // R4, R5, R6: full programming in both pair orders
    addrSel = 2'd2;
    for (int k = 0; k < 8; k++) begin
      logic [16:0] r;
      logic [7:0] fa, fb, ca, cb;
      r  = 17'((k * 24593 + 4097 * k * k + 3) & 32'h1FFFF);
      fa = {1'b0, r[14:8]};
      fb = r[7:0];
      ca = {1'b1, r[16:15], 1'(k), 4'(k + 1)};
      cb = {4'(15 - k), 4'(k * 3)};
      addrWrite();
      if (k % 2 == 0) begin
        writeData(fa); writeData(fb);
        check("R6 no commit after freq pair", 32'(ratioOut), 32'(eRatio));
        writeData(ca);
        check("R6 commit on 17 bits", 32'(ratioOut), 32'(r));
        writeData(cb);
      end else begin
        writeData(ca);
        check("R5 prescaler immediate", 32'(prescEn), 32'(ca[4]));
        check("R5 ref code immediate", 32'(refCode), 32'(ca[3:0]));
        writeData(cb);
        check("R5 port bits", 32'(portBits), 32'(cb[3:0]));
        writeData(fa);
        check("R6 no commit mid pair", 32'(ratioOut), 32'(eRatio));
        writeData(fb);
        check("R6 commit in control-first order", 32'(ratioOut), 32'(r));
      end
      busStop(); mStop();
      checkOuts("R4 full program");
    end

    // R6, R7: frequency-only pairs, then STOP commits
    addrWrite();
    writeData(8'h15); writeData(8'hA7);
    check("R6 freq pair alone", 32'(ratioOut), 32'(eRatio));
    writeData(8'h2C); writeData(8'h3E);
    check("R6 repeated freq pair", 32'(ratioOut), 32'(eRatio));
    busStop(); mStop();
    check("R7 stop commits freq pair", 32'(ratioOut), 32'(eRatio));
    checkOuts("R7 freq pair");

    // R7: single frequency-high byte then STOP
    addrWrite(); writeData(8'h61); busStop(); mStop();
    checkOuts("R7 hi only");

    // R7: single control-A byte then STOP
    addrWrite(); writeData(8'hC9); busStop(); mStop();
    checkOuts("R7 ctrl-A only");

    // R7: STOP cuts the low byte short
    addrWrite(); writeData(8'h0B);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStop(); mStop();
    checkOuts("R7 partial byte discarded");

    // R4: a START resets pairing
    addrWrite(); writeData(8'h22);
    addrWrite(); writeData(8'h9A);
    check("R4 restart treats byte as control", 32'(refCode), 32'hA);
    busStop(); mStop();
    checkOuts("R4 restart");

    finishRun();
  end
endmodule